// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Burst SRAM

This block is a synchronous, pipelined word memory that never needs an idle cycle when the traffic switches between reads and writes. Every control and address input is sampled on the rising clock edge. A command edge registers the address and the operation type. A read returns its word from the output register one enabled edge later. A write takes its data from the data-in bus two enabled edges after the command. Read data and write data therefore occupy the bus in the same relative cycle, so any mix of reads and writes can be issued on every cycle.

The word is split into byte lanes, and each lane has its own active-low write enable. A two-bit burst counter steps through four neighbouring words in linear or interleaved order without a new address. A global active-low clock enable freezes the whole pipeline. The output drive is split from the data: the block gives a data-out word and a drive-enable flag, and the flag is gated by an asynchronous active-low output enable. A read that hits a write still waiting for its data receives the newest bytes through a bypass path.

Top module: `zt_burst_sram`

## Requirements
- R1: After reset, and before any read has completed, `rdata_oe` is low whatever `out_en_n` is.
- R2: A read is issued at an enabled edge with `load_n` low, all three selects active (`csel_a_n`=0, `csel_b`=1, `csel_c_n`=0) and `wr_n` high. The stored word appears on `rdata` after the next enabled edge, and `rdata_oe` is high while `out_en_n` is low.
- R3: `out_en_n` gates `rdata_oe` without a clock: while read data is held, raising `out_en_n` drops the drive and lowering it restores the drive.
- R4: A write is issued like a read but with `wr_n` low. `rdata_oe` is low for the cycle after the next enabled edge, whatever `out_en_n` is. `wdata` is sampled at the second enabled edge after the command.
- R5: A write changes only lane k, bits [9k+8:9k], for each k where `lane_wr_n[k]` was 0 at that beat's edge. All other lanes keep their contents.
- R6: Reads and writes can alternate on every enabled edge with no idle cycle, and each returns or stores the right data.
- R7: A read issued on the edge right after a write to the same address returns the merged word, with the newly written lanes and the old remaining lanes.
- R8: An edge with `load_n` low and any select inactive deselects the block. `rdata_oe` is low after the following enabled edge.
- R9: While `clk_en_n` is high, edges are ignored: `rdata`, `rdata_oe`, pending writes and burst state all hold.
- R10: With `burst_ilv`=0 at the load edge, each edge with `load_n` high moves to the next word. The two low address bits become (start + n) mod 4 for the n-th advance, wrapping with no end.
- R11: With `burst_ilv`=1 at the load edge, the n-th advance uses low address bits start XOR (n mod 4).
- R12: During an advance, the selects and `wr_n` are ignored. The burst keeps the read or write type it was loaded with.
- R13: An advance that follows a deselect does nothing: no read data is driven and no word is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control pipeline |
| clk_en_n | input | 1 | Active-low clock enable; high freezes all state |
| csel_a_n | input | 1 | Active-low select |
| csel_b | input | 1 | Active-high select |
| csel_c_n | input | 1 | Active-low select |
| load_n | input | 1 | Low loads a new command and address; high advances the burst |
| wr_n | input | 1 | Low requests a write, high a read (sampled at load edges) |
| lane_wr_n | input | LANES | Active-low per-lane write enables |
| burst_ilv | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data, sampled two enabled edges after the write command |
| rdata | output | LANES*LANE_W | Registered read data |
| rdata_oe | output | 1 | High when the read data should drive the external bus |

## Verification
The bench first fills a region with unique words. It then runs pure read streams and pure write streams against the fill, which checks the basic latencies. Alternating read/write streams show that no idle cycle is needed. Write-then-read pairs to the same address, swept over all sixteen lane masks, separate a working bypass from one that returns stale data or merges the wrong lanes. The bench starts a burst from each of the four start offsets in both orders and runs it past the wrap. During the advances it toggles the selects and `wr_n`, and it inserts clock-enable stalls in the middle of writes and bursts. Together these separate counter order, wrap behaviour, the latched burst type and the freezing of pending write capture.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

   localparam int unsigned BURST_W = 2;

   typedef enum logic {
      SEQ_LINEAR     = 1'b0,
      SEQ_INTERLEAVE = 1'b1
   } seq_mode_e;

   typedef logic [BURST_W-1:0] beat_t;

   // Low address bits of a burst beat, given the start offset and the step count.
   function automatic beat_t beat_offset(beat_t start, beat_t step, seq_mode_e mode);
      beat_t res;
      if (mode == SEQ_INTERLEAVE) res = start ^ step;
      else                        res = beat_t'(start + step);
      return res;
   endfunction

endpackage

// File: rtl/zt_burst_seq.sv
module zt_burst_seq
   import zt_sram_pkg::*;
#(
   parameter int unsigned ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              advance,
   input  logic [ADDR_W-1:0] load_addr,
   input  seq_mode_e         load_mode,
   output logic [ADDR_W-1:0] next_addr
);

   logic [ADDR_W-1:0] base_q;
   beat_t             cnt_q;
   beat_t             cnt_nx;
   seq_mode_e         mode_q;

   assign cnt_nx    = beat_t'(cnt_q + 1'b1);
   assign next_addr = {base_q[ADDR_W-1:BURST_W],
                       beat_offset(base_q[BURST_W-1:0], cnt_nx, mode_q)};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
         mode_q <= SEQ_LINEAR;
      end else if (load) begin
         base_q <= load_addr;
         cnt_q  <= '0;
         mode_q <= load_mode;
      end else if (advance) begin
         cnt_q  <= cnt_nx;
      end
   end

endmodule

// File: rtl/zt_sram_array.sv
module zt_sram_array #(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned LANES  = 4,
   parameter int unsigned LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [LANES-1:0]        wr_lane_n,
   input  logic [LANES*LANE_W-1:0] wr_data,
   input  logic [ADDR_W-1:0]       rd_addr,
   output logic [LANES*LANE_W-1:0] rd_data
);

   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic addr_hit;
   assign addr_hit = wr_en && (wr_addr == rd_addr);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] lane_mem [DEPTH];
      logic              lane_we;

      assign lane_we = wr_en && !wr_lane_n[g];

      always_ff @(posedge clk) begin
         if (lane_we) lane_mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
      end

      // Bypass: a write retiring on this edge wins over the stored lane.
      assign rd_data[g*LANE_W +: LANE_W] =
         (addr_hit && !wr_lane_n[g]) ? wr_data[g*LANE_W +: LANE_W]
                                     : lane_mem[rd_addr];
   end

endmodule

// File: rtl/zt_out_stage.sv
module zt_out_stage #(
   parameter int unsigned WORD_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              load_read,
   input  logic [WORD_W-1:0] rd_word,
   input  logic              write_wait,
   input  logic              out_en_n,
   output logic [WORD_W-1:0] rdata,
   output logic              rd_valid,
   output logic              rdata_oe
);

   logic [WORD_W-1:0] data_q;
   logic              valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q  <= '0;
         valid_q <= 1'b0;
      end else if (en) begin
         valid_q <= load_read;
         if (load_read) data_q <= rd_word;
      end
   end

   assign rdata    = data_q;
   assign rd_valid = valid_q;
   assign rdata_oe = valid_q && !out_en_n && !write_wait;

   // R9: a stalled edge leaves the output register untouched
   a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ($stable(data_q) && $stable(valid_q)));

endmodule

// File: rtl/zt_burst_sram.sv
module zt_burst_sram
   import zt_sram_pkg::*;
#(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned LANES  = 4,
   parameter int unsigned LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clk_en_n,
   input  logic                    csel_a_n,
   input  logic                    csel_b,
   input  logic                    csel_c_n,
   input  logic                    load_n,
   input  logic                    wr_n,
   input  logic [LANES-1:0]        lane_wr_n,
   input  logic                    burst_ilv,
   input  logic                    out_en_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] rdata,
   output logic                    rdata_oe
);

   localparam int unsigned WORD_W = LANES * LANE_W;

   initial begin
      assert (ADDR_W > BURST_W) else $error("ADDR_W must exceed the burst counter width");
      assert (LANES >= 1)       else $error("LANES must be at least 1");
      assert (LANE_W >= 1)      else $error("LANE_W must be at least 1");
   end

   logic              en;
   logic              chips_on;
   logic              seq_load;
   logic              seq_adv;
   logic [ADDR_W-1:0] seq_addr;

   // Stage 1: command accepted at the last enabled edge
   logic              s1_valid;
   logic              s1_write;
   logic [ADDR_W-1:0] s1_addr;
   logic [LANES-1:0]  s1_lane_n;
   // Stage 2: write waiting for its data on the bus
   logic              s2_valid;
   logic [ADDR_W-1:0] s2_addr;
   logic [LANES-1:0]  s2_lane_n;

   logic [WORD_W-1:0] arr_word;
   logic              rd_valid;

   assign en       = !clk_en_n;
   assign chips_on = !csel_a_n && csel_b && !csel_c_n;
   assign seq_load = en && !load_n && chips_on;
   assign seq_adv  = en && load_n && s1_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid  <= 1'b0;
         s1_write  <= 1'b0;
         s1_addr   <= '0;
         s1_lane_n <= '1;
         s2_valid  <= 1'b0;
         s2_addr   <= '0;
         s2_lane_n <= '1;
      end else if (en) begin
         if (!load_n) begin
            s1_valid <= chips_on;
            s1_write <= !wr_n;
            s1_addr  <= addr;
         end else begin
            s1_addr  <= seq_addr;
         end
         s1_lane_n <= lane_wr_n;
         s2_valid  <= s1_valid && s1_write;
         s2_addr   <= s1_addr;
         s2_lane_n <= s1_lane_n;
      end
   end

   zt_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (seq_load),
      .advance   (seq_adv),
      .load_addr (addr),
      .load_mode (seq_mode_e'(burst_ilv)),
      .next_addr (seq_addr)
   );

   zt_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
      .clk       (clk),
      .wr_en     (en && s2_valid),
      .wr_addr   (s2_addr),
      .wr_lane_n (s2_lane_n),
      .wr_data   (wdata),
      .rd_addr   (s1_addr),
      .rd_data   (arr_word)
   );

   zt_out_stage #(.WORD_W(WORD_W)) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en),
      .load_read  (s1_valid && !s1_write),
      .rd_word    (arr_word),
      .write_wait (s2_valid),
      .out_en_n   (out_en_n),
      .rdata      (rdata),
      .rd_valid   (rd_valid),
      .rdata_oe   (rdata_oe)
   );

   // R2: an accepted read fills the output register at the next enabled edge
   a_r2_read_fills: assert property (@(posedge clk) disable iff (!rst_n)
      (en && s1_valid && !s1_write) |=> rd_valid);

   // R4: the cycle after a write leaves stage 1 never drives the bus
   a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
      (en && s1_valid && s1_write) |=> !rdata_oe);

   // R6: read data and pending write data never share a cycle
   a_r6_no_clash: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_valid && s2_valid));

   // R13: an advance with no live burst issues nothing
   a_r13_idle_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (en && load_n && !s1_valid) |=> !s1_valid);

endmodule

// File: tb/zt_burst_sram_bench.sv
module zt_burst_sram_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        clk_en_n, csel_a_n, csel_b, csel_c_n, load_n, wr_n, burst_ilv, out_en_n;
   logic [3:0]  lane_wr_n;
   logic [9:0]  addr;
   logic [35:0] wdata;
   logic [35:0] rdata;
   logic        rdata_oe;

   always #5 clk = ~clk;

   zt_burst_sram u_zt_burst_sram (
      .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .csel_a_n(csel_a_n),
      .csel_b(csel_b), .csel_c_n(csel_c_n), .load_n(load_n), .wr_n(wr_n),
      .lane_wr_n(lane_wr_n), .burst_ilv(burst_ilv), .out_en_n(out_en_n),
      .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
   );

   typedef struct {
      logic       v;
      logic       w;
      logic [9:0] a;
      logic [3:0] l;
   } cmd_t;

   int          errs = 0;
   int          checks = 0;
   logic [35:0] ref_mem [1024];
   cmd_t        p1, p2;
   logic        exp_valid;
   logic [35:0] exp_data;
   logic [35:0] last_rdata;
   int          wseed = 0;
   logic        b_act, b_wr, b_mode;
   logic [9:0]  b_base;
   logic [1:0]  b_cnt;

   task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [35:0] mkdata(input int s);
      logic [8:0] b = s[8:0];
      return {b + 9'd201, b + 9'd77, b + 9'd13, b};
   endfunction

   task automatic issue(input string tag, input logic ckn, input logic ldn,
                        input logic [2:0] sel, input logic wen, input logic [3:0] ln,
                        input logic [9:0] a, input logic md);
      cmd_t       cur;
      logic [1:0] lo;
      clk_en_n = ckn; load_n = ldn; {csel_a_n, csel_b, csel_c_n} = sel;
      wr_n = wen; lane_wr_n = ln; addr = a; burst_ilv = md;
      if (ckn) begin
         @(posedge clk); @(negedge clk);
         chk(tag, {35'd0, rdata_oe}, {35'd0, exp_valid && !out_en_n});
         chk(tag, rdata, last_rdata);
         return;
      end
      if (!ldn) begin
         cur = '{v: (sel == 3'b010), w: !wen, a: a, l: ln};
         if (sel == 3'b010) begin
            b_act = 1'b1; b_base = a; b_cnt = 2'd0; b_mode = md; b_wr = !wen;
         end else b_act = 1'b0;
      end else begin
         b_cnt = b_cnt + 2'd1;
         lo = b_mode ? (b_base[1:0] ^ b_cnt) : (b_base[1:0] + b_cnt);
         cur = '{v: b_act, w: b_wr, a: {b_base[9:2], lo}, l: ln};
      end
      if (p2.v && p2.w) begin
         wseed += 5;
         wdata = mkdata(wseed);
      end
      @(posedge clk); @(negedge clk);
      if (p2.v && p2.w)
         for (int k = 0; k < 4; k++)
            if (!p2.l[k]) ref_mem[p2.a][k*9 +: 9] = wdata[k*9 +: 9];
      if (p1.v && !p1.w) begin
         exp_valid = 1'b1;
         exp_data  = ref_mem[p1.a];
      end else exp_valid = 1'b0;
      p2 = p1;
      p1 = cur;
      chk(tag, {35'd0, rdata_oe}, {35'd0, exp_valid && !out_en_n});
      if (exp_valid) chk(tag, rdata, exp_data);
      last_rdata = rdata;
   endtask

   task automatic rd(input string tag, input logic [9:0] a);
      issue(tag, 1'b0, 1'b0, 3'b010, 1'b1, 4'hF, a, 1'b0);
   endtask
   task automatic wr(input string tag, input logic [9:0] a, input logic [3:0] ln);
      issue(tag, 1'b0, 1'b0, 3'b010, 1'b0, ln, a, 1'b0);
   endtask
   task automatic nop(input string tag);
      issue(tag, 1'b0, 1'b0, 3'b111, 1'b1, 4'hF, 10'd0, 1'b0);
   endtask
   task automatic stall(input string tag);
      issue(tag, 1'b1, 1'b0, 3'b010, 1'b0, 4'h0, 10'h3FF, 1'b1);
   endtask
   task automatic flush(input string tag);
      nop(tag); nop(tag);
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errs, checks);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errs++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      for (int i = 0; i < 1024; i++) ref_mem[i] = '0;
      p1 = '{v: 1'b0, w: 1'b0, a: '0, l: '1};
      p2 = p1;
      exp_valid = 1'b0; exp_data = '0; last_rdata = '0;
      b_act = 1'b0; b_wr = 1'b0; b_mode = 1'b0; b_base = '0; b_cnt = '0;
      rst_n = 1'b0; clk_en_n = 1'b0; csel_a_n = 1'b1; csel_b = 1'b0; csel_c_n = 1'b1;
      load_n = 1'b0; wr_n = 1'b1; lane_wr_n = 4'hF; burst_ilv = 1'b0; out_en_n = 1'b0;
      addr = '0; wdata = '0;
      repeat (3) @(negedge clk);
      chk("R1", {35'd0, rdata_oe}, 36'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", {35'd0, rdata_oe}, 36'd0);
      last_rdata = rdata;

      // Fill then read back a 64-word region (R4, R2)
      for (int i = 0; i < 64; i++) wr("R4", 10'(i), 4'h0);
      flush("R4");
      for (int i = 0; i < 64; i++) rd("R2", 10'(i));
      flush("R2");

      // Alternating write/read every cycle (R6)
      for (int i = 0; i < 32; i++) begin
         wr("R6", 10'(i), 4'h0);
         rd("R6", 10'((i * 7 + 3) % 64));
      end
      flush("R6");

      // Write immediately followed by read of the same word, all lane masks (R7)
      wr("R7", 10'd100, 4'h0);
      for (int m = 0; m < 16; m++) begin
         wr("R7", 10'd100, 4'(m));
         rd("R7", 10'd100);
      end
      flush("R7");

      // Lane isolation with a delayed read (R5)
      for (int m = 0; m < 16; m++) begin
         wr("R5", 10'd200, 4'h0);
         wr("R5", 10'd200, 4'(m));
         nop("R5"); nop("R5");
         rd("R5", 10'd200);
      end
      flush("R5");

      // Asynchronous output enable (R3)
      rd("R3", 10'd9);
      out_en_n = 1'b1;
      nop("R3");
      chk("R3", {35'd0, rdata_oe}, 36'd0);
      out_en_n = 1'b0; #1;
      chk("R3", {35'd0, rdata_oe}, 36'd1);
      chk("R3", rdata, ref_mem[9]);
      out_en_n = 1'b1; #1;
      chk("R3", {35'd0, rdata_oe}, 36'd0);
      out_en_n = 1'b0;
      flush("R3");

      // Pipelined deselect with each select failing in turn (R8)
      rd("R8", 10'd11);
      issue("R8", 1'b0, 1'b0, 3'b110, 1'b1, 4'hF, 10'd12, 1'b0);
      rd("R8", 10'd13);
      issue("R8", 1'b0, 1'b0, 3'b000, 1'b1, 4'hF, 10'd14, 1'b0);
      issue("R8", 1'b0, 1'b0, 3'b011, 1'b0, 4'h0, 10'd15, 1'b0);
      flush("R8");

      // Read bursts, every start offset, past the wrap (R10, R11, R12)
      for (int md = 0; md < 2; md++)
         for (int b = 0; b < 4; b++) begin
            issue(md ? "R11" : "R10", 1'b0, 1'b0, 3'b010, 1'b1, 4'hF, 10'(20 + b), 1'(md));
            for (int s = 0; s < 6; s++)
               issue(md ? "R11" : "R10", 1'b0, 1'b1, 3'(s * 3), 1'(s & 1), 4'hF, 10'h3FF, 1'(md ^ 1));
            flush("R12");
         end

      // Write bursts with junk selects and wr_n during advances (R12)
      for (int md = 0; md < 2; md++) begin
         issue("R12", 1'b0, 1'b0, 3'b010, 1'b0, 4'h0, 10'(41 + md), 1'(md));
         for (int s = 0; s < 3; s++)
            issue("R12", 1'b0, 1'b1, 3'b101, 1'b1, 4'(s * 5), 10'd0, 1'b0);
         flush("R12");
         for (int i = 40; i < 44; i++) rd("R12", 10'(i));
         flush("R12");
      end

      // Advance after deselect does nothing (R13)
      nop("R13");
      for (int s = 0; s < 3; s++) issue("R13", 1'b0, 1'b1, 3'b010, 1'b0, 4'h0, 10'd0, 1'b0);
      flush("R13");
      for (int i = 0; i < 4; i++) rd("R13", 10'(i));
      flush("R13");

      // Clock-enable stalls in reads, writes and bursts (R9)
      rd("R9", 10'd5);
      stall("R9"); stall("R9");
      rd("R9", 10'd6);
      wr("R9", 10'd7, 4'h0);
      stall("R9");
      nop("R9");
      stall("R9"); stall("R9");
      nop("R9");
      rd("R9", 10'd7);
      issue("R9", 1'b0, 1'b0, 3'b010, 1'b1, 4'hF, 10'd30, 1'b1);
      issue("R9", 1'b0, 1'b1, 3'b111, 1'b0, 4'h0, 10'd0, 1'b0);
      stall("R9");
      issue("R9", 1'b0, 1'b1, 3'b111, 1'b0, 4'h0, 10'd0, 1'b0);
      stall("R9");
      issue("R9", 1'b0, 1'b1, 3'b111, 1'b0, 4'h0, 10'd0, 1'b0);
      flush("R9");

      summary();
      $finish;
   end

endmodule